// File: doc/BRIEF.md
# Timekeeper Alarm Repeat Controller

This block holds four alarm bytes (second, minute, hour, day of month) in BCD and watches an external running calendar. On every rising edge of a once-per-second tick it compares the calendar with the alarm fields and, on a hit, emits a one-cycle interrupt pulse. The top bit of each alarm byte is a mask bit. The four mask bits together select how often the alarm repeats: monthly, daily, hourly, every minute or every second.

Software loads the alarm bytes through a byte-wide write channel. Each field checks its decoded BCD value against its legal range, and a write outside that range is dropped. The channel uses valid/ready. A write is taken in any cycle where both `wr_valid_i` and `wr_ready_o` are high. Ready goes low only during reset and the first clock edge after it, so the channel never applies back-pressure in normal operation. The calendar counter itself is outside this block. Its BCD values arrive on plain input pins.

Top module: `alarm_repeat_unit`

## Requirements
- R1: While reset is asserted and after it, before any write, all four alarm bytes read 0x00 and `irq_o` is low.
- R2: A write taken on a clock edge targets the field given by `wr_sel_i` (0 = second, 1 = minute, 2 = hour, 3 = date). If accepted, the whole data byte, including bit 7, appears on that field's output after the edge. Without a taken write, every alarm byte holds its value.
- R3: A write to the second or minute field decodes bits 6:4 as tens and bits 3:0 as ones (value = tens*10 + ones). It is stored only if that value is 59 or less, and is otherwise ignored.
- R4: A write to the hour field decodes bits 5:4 as tens and bits 3:0 as ones. It is stored only if the value is 23 or less.
- R5: A write to the date field decodes bits 5:4 as tens and bits 3:0 as ones. It is stored only if the value lies from 1 to 31.
- R6: With all four mask bits clear, a tick fires the alarm only when second (bits 6:0), minute (bits 6:0), hour (bits 5:0) and date (bits 5:0) all equal the calendar.
- R7: With only the date mask set, a tick fires when second, minute and hour match, and the date is ignored.
- R8: With the date and hour masks set and the minute and second masks clear, a tick fires when second and minute match.
- R9: With the date, hour and minute masks set and the second mask clear, a tick fires when the second matches.
- R10: Any other mask combination fires the alarm on every tick, whatever the calendar holds.
- R11: `irq_o` is high for exactly one cycle, in the cycle after the clock edge that sees the tick rise. A tick held high for several cycles produces only one pulse.
- R12: `wr_ready_o` is low during reset and high from the second clock edge after reset release onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Alarm write request |
| wr_ready_o | output | 1 | Write channel ready |
| wr_sel_i | input | 2 | Target field: 0 second, 1 minute, 2 hour, 3 date |
| wr_data_i | input | 8 | Write byte, bit 7 is the mask |
| tick_i | input | 1 | Once-per-second tick, rising edge counts |
| cal_sec_i | input | 8 | Calendar seconds, BCD |
| cal_min_i | input | 8 | Calendar minutes, BCD |
| cal_hour_i | input | 8 | Calendar hours, BCD |
| cal_date_i | input | 8 | Calendar day of month, BCD |
| alm_sec_o | output | 8 | Stored alarm second byte |
| alm_min_o | output | 8 | Stored alarm minute byte |
| alm_hour_o | output | 8 | Stored alarm hour byte |
| alm_date_o | output | 8 | Stored alarm date byte |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
The bench builds the block with its default package constants: 8-bit BCD bytes, four fields, and 7/7/6/6 decoded bits. With these, both tens widths and all three range limits (59, 23, 1..31) are reachable through the write channel, and the rejected codes include non-decimal nibbles such as 0x5A. Every step of the mask ladder is reachable, including mask combinations that fall outside the ladder, so each repeat rate and its irregular fall-through to the per-second rate is exercised. Directed cases hit the field boundaries and a tick held high, and randomized rounds mix these cases with near-miss calendars.

// File: rtl/alarm_rpt_pkg.sv
package alarm_rpt_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned NUM_FIELDS  = 4;
  localparam int unsigned FIELD_SEL_W = $clog2(NUM_FIELDS);

  typedef enum logic [FIELD_SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } field_e;

  typedef enum logic [2:0] {
    RATE_MONTH = 3'd0,
    RATE_DAY   = 3'd1,
    RATE_HOUR  = 3'd2,
    RATE_MIN   = 3'd3,
    RATE_SEC   = 3'd4
  } rate_e;

  // number of low bits that carry the BCD value of field f
  function automatic int unsigned fld_bits(input int unsigned f);
    return (f < 2) ? 7 : 6;
  endfunction

  function automatic int unsigned fld_lo(input int unsigned f);
    return (f == 3) ? 1 : 0;
  endfunction

  function automatic int unsigned fld_hi(input int unsigned f);
    case (f)
      0, 1:    return 59;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  // BCD to binary; 'wide' selects a 3-bit tens digit, else 2 bits
  function automatic logic [BYTE_W-1:0] bcd_decode(input logic [BYTE_W-1:0] v,
                                                   input logic wide);
    logic [2:0] tens;
    tens = wide ? v[6:4] : {1'b0, v[5:4]};
    return ({5'd0, tens} * 8'd10) + {4'd0, v[3:0]};
  endfunction

endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
  import alarm_rpt_pkg::*;
#(
  parameter int unsigned VAL_BITS = 7,
  parameter int unsigned LO       = 0,
  parameter int unsigned HI       = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] q
);

  localparam logic WIDE_TENS = (VAL_BITS == 7);

  logic [BYTE_W-1:0] dec_val;
  logic              lo_ok;
  logic              hi_ok;

  assign dec_val = bcd_decode(wr_data, WIDE_TENS);
  assign hi_ok   = (dec_val <= BYTE_W'(HI));

  generate
    if (LO == 0) begin : g_no_floor
      assign lo_ok = 1'b1;
    end else begin : g_floor
      assign lo_ok = (dec_val >= BYTE_W'(LO));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en && lo_ok && hi_ok) begin
      q <= wr_data;
    end
  end

endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode
  import alarm_rpt_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] masks,
  output rate_e                 rate
);

  // masks index: 0 second, 1 minute, 2 hour, 3 date
  always_comb begin
    unique case (masks)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_rpt_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  rate_e                               rate,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0]   alarm,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0]   cal,
  output logic                                irq
);

  logic [NUM_FIELDS-1:0] fld_en;
  logic [NUM_FIELDS-1:0] fld_eq;
  logic                  hit;
  logic                  tick_q;
  logic                  tick_edge;

  always_comb begin
    unique case (rate)
      RATE_MONTH: fld_en = 4'b1111;
      RATE_DAY:   fld_en = 4'b0111;
      RATE_HOUR:  fld_en = 4'b0011;
      RATE_MIN:   fld_en = 4'b0001;
      default:    fld_en = 4'b0000;
    endcase
  end

  generate
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
      localparam int unsigned W = fld_bits(f);
      assign fld_eq[f] = (alarm[f][W-1:0] == cal[f][W-1:0]);
    end
  endgenerate

  assign hit       = &(fld_eq | ~fld_en);
  assign tick_edge = tick & ~tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      tick_q <= tick;
      irq    <= tick_edge & hit;
    end
  end

endmodule

// File: rtl/alarm_repeat_unit.sv
module alarm_repeat_unit
  import alarm_rpt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid_i,
  output logic                   wr_ready_o,
  input  logic [FIELD_SEL_W-1:0] wr_sel_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  input  logic                   tick_i,
  input  logic [BYTE_W-1:0]      cal_sec_i,
  input  logic [BYTE_W-1:0]      cal_min_i,
  input  logic [BYTE_W-1:0]      cal_hour_i,
  input  logic [BYTE_W-1:0]      cal_date_i,
  output logic [BYTE_W-1:0]      alm_sec_o,
  output logic [BYTE_W-1:0]      alm_min_o,
  output logic [BYTE_W-1:0]      alm_hour_o,
  output logic [BYTE_W-1:0]      alm_date_o,
  output logic                   irq_o
);

  logic                              ready_q;
  logic                              wr_fire;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_q;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] cal_v;
  logic [NUM_FIELDS-1:0]             masks;
  rate_e                             rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign wr_ready_o = ready_q;
  assign wr_fire    = wr_valid_i & ready_q;

  assign cal_v[FLD_SEC]  = cal_sec_i;
  assign cal_v[FLD_MIN]  = cal_min_i;
  assign cal_v[FLD_HOUR] = cal_hour_i;
  assign cal_v[FLD_DATE] = cal_date_i;

  generate
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      alarm_field_reg #(
        .VAL_BITS (fld_bits(f)),
        .LO       (fld_lo(f)),
        .HI       (fld_hi(f))
      ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire && (wr_sel_i == FIELD_SEL_W'(f))),
        .wr_data (wr_data_i),
        .q       (alm_q[f])
      );
      assign masks[f] = alm_q[f][BYTE_W-1];
    end
  endgenerate

  alarm_rate_decode u_rate (
    .masks (masks),
    .rate  (rate)
  );

  alarm_match u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_i),
    .rate  (rate),
    .alarm (alm_q),
    .cal   (cal_v),
    .irq   (irq_o)
  );

  assign alm_sec_o  = alm_q[FLD_SEC];
  assign alm_min_o  = alm_q[FLD_MIN];
  assign alm_hour_o = alm_q[FLD_HOUR];
  assign alm_date_o = alm_q[FLD_DATE];

endmodule

// File: rtl/alarm_repeat_checker.sv
module alarm_repeat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid_i,
  input logic       wr_ready_o,
  input logic [1:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       tick_i,
  input logic [7:0] alm_sec_o,
  input logic [7:0] alm_min_o,
  input logic [7:0] alm_hour_o,
  input logic [7:0] alm_date_o,
  input logic       irq_o
);

  logic       taken;
  logic [7:0] v7;
  logic [7:0] v6;

  assign taken = wr_valid_i && wr_ready_o;
  assign v7 = ({5'd0, wr_data_i[6:4]} * 8'd10) + {4'd0, wr_data_i[3:0]};
  assign v6 = ({6'd0, wr_data_i[5:4]} * 8'd10) + {4'd0, wr_data_i[3:0]};

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> $stable({alm_sec_o, alm_min_o, alm_hour_o, alm_date_o}));

  assert_sec_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && wr_sel_i == 2'd0 && v7 > 8'd59) |=> $stable(alm_sec_o));

  assert_hour_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && wr_sel_i == 2'd2 && v6 <= 8'd23) |=> (alm_hour_o == $past(wr_data_i)));

  assert_date_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && wr_sel_i == 2'd3 && (v6 == 8'd0 || v6 > 8'd31)) |=> $stable(alm_date_o));

  assert_sec_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tick_i) && alm_sec_o[7]) |=> irq_o);

  assert_pulse_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tick_i));

endmodule

bind alarm_repeat_unit alarm_repeat_checker u_alarm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .tick_i     (tick_i),
  .alm_sec_o  (alm_sec_o),
  .alm_min_o  (alm_min_o),
  .alm_hour_o (alm_hour_o),
  .alm_date_o (alm_date_o),
  .irq_o      (irq_o)
);

// File: tb/test_alarm_repeat_unit.sv
module test_alarm_repeat_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic       wr_ready_o;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       tick_i = 1'b0;
  logic [7:0] cal_sec_i = '0, cal_min_i = '0, cal_hour_i = '0, cal_date_i = '0;
  logic [7:0] alm_sec_o, alm_min_o, alm_hour_o, alm_date_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [4];

  always #5 clk = ~clk;

  alarm_repeat_unit i_alarm_repeat_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dec(input logic [7:0] d, input bit wide);
    int t = wide ? int'(d[6:4]) : int'(d[5:4]);
    return 8'(t * 10 + int'(d[3:0]));
  endfunction

  function automatic bit legal(input int sel, input logic [7:0] d);
    if (sel < 2)  return dec(d, 1) <= 59;
    if (sel == 2) return dec(d, 0) <= 23;
    return dec(d, 0) >= 1 && dec(d, 0) <= 31;
  endfunction

  function automatic string rate_req();
    logic [3:0] m = {mdl[3][7], mdl[2][7], mdl[1][7], mdl[0][7]};
    case (m)
      4'b0000: return "R6";
      4'b1000: return "R7";
      4'b1100: return "R8";
      4'b1110: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic bit exp_fire(input logic [7:0] c [4]);
    bit s = mdl[0][6:0] == c[0][6:0];
    bit mi = mdl[1][6:0] == c[1][6:0];
    bit h = mdl[2][5:0] == c[2][5:0];
    bit d = mdl[3][5:0] == c[3][5:0];
    string r = rate_req();
    if (r == "R6") return s && mi && h && d;
    if (r == "R7") return s && mi && h;
    if (r == "R8") return s && mi;
    if (r == "R9") return s;
    return 1'b1;
  endfunction

  function automatic logic [7:0] rd_field(input int sel);
    case (sel)
      0: return alm_sec_o;
      1: return alm_min_o;
      2: return alm_hour_o;
      default: return alm_date_o;
    endcase
  endfunction

  task automatic wr(input int sel, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_sel_i = 2'(sel); wr_data_i = d;
    @(negedge clk);
    wr_valid_i = 1'b0;
    if (legal(sel, d)) mdl[sel] = d;
    chk(req, {24'd0, rd_field(sel)}, {24'd0, mdl[sel]});
  endtask

  task automatic tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input logic [7:0] d, input string req);
    logic [7:0] c [4];
    c[0] = s; c[1] = m; c[2] = h; c[3] = d;
    @(negedge clk);
    cal_sec_i = s; cal_min_i = m; cal_hour_i = h; cal_date_i = d; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk(req, {31'd0, irq_o}, {31'd0, exp_fire(c)});
    @(negedge clk);
    chk("R11", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    #(10 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 / R12: reset state
    chk("R1", {alm_sec_o, alm_min_o, alm_hour_o, alm_date_o}, 32'd0);
    chk("R1", {31'd0, irq_o}, 32'd0);
    chk("R12", {31'd0, wr_ready_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12", {31'd0, wr_ready_o}, 32'd1);

    // directed range checks
    wr(0, 8'h59, "R3");
    wr(0, 8'h60, "R3");
    wr(1, 8'h5A, "R3");
    wr(1, 8'h45, "R3");
    wr(2, 8'h24, "R4");
    wr(2, 8'h23, "R4");
    wr(2, 8'h9F, "R4");
    wr(2, 8'h85, "R4");
    wr(3, 8'h00, "R5");
    wr(3, 8'h32, "R5");
    wr(3, 8'h31, "R5");
    wr(3, 8'h81, "R5");
    chk("R2", {alm_sec_o, alm_min_o, alm_hour_o, alm_date_o}, 32'h59458581);

    // monthly
    wr(0, 8'h30, "R2"); wr(1, 8'h15, "R2"); wr(2, 8'h12, "R2"); wr(3, 8'h07, "R2");
    tick(8'h30, 8'h15, 8'h12, 8'h07, "R6");
    tick(8'h30, 8'h15, 8'h12, 8'h08, "R6");
    // daily
    wr(3, 8'h87, "R2");
    tick(8'h30, 8'h15, 8'h12, 8'h09, "R7");
    tick(8'h30, 8'h15, 8'h13, 8'h07, "R7");
    // hourly
    wr(2, 8'h92, "R2");
    tick(8'h30, 8'h15, 8'h05, 8'h21, "R8");
    tick(8'h30, 8'h16, 8'h12, 8'h07, "R8");
    // minutely
    wr(1, 8'h95, "R2");
    tick(8'h30, 8'h44, 8'h05, 8'h21, "R9");
    tick(8'h31, 8'h15, 8'h12, 8'h07, "R9");
    // per second, and an off-ladder combination
    wr(0, 8'hB0, "R2");
    tick(8'h01, 8'h02, 8'h03, 8'h04, "R10");
    wr(0, 8'h30, "R2"); wr(1, 8'h15, "R2"); wr(3, 8'h07, "R2");
    tick(8'h01, 8'h02, 8'h03, 8'h04, "R10");

    // R11: tick held high gives one pulse
    @(negedge clk);
    tick_i = 1'b1;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (irq_o) seen++;
    end
    tick_i = 1'b0;
    chk("R11", 32'(seen), 32'd1);

    // randomized rounds
    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom);
      logic [7:0] c [4];
      int pert;
      if ($urandom_range(0, 2) == 0) d = {d[7], 3'($urandom_range(0, 5)), 4'($urandom_range(0, 9))};
      wr(sel, d, "R2");
      for (int f = 0; f < 4; f++) c[f] = mdl[f] & 8'h7F;
      pert = int'($urandom_range(0, 7));
      if (pert < 4) c[pert] = c[pert] ^ 8'h01;
      tick(c[0], c[1], c[2], c[3], rate_req());
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule